// File: doc/BRIEF.md
# Host Wake Event Interrupt Controller

This block gathers wake events from the host side into sticky status bits and masks them with an enable register of the same layout. It drives a single level-high interrupt request to the embedded core. There are five event sources:

- two ring-indicator lines;
- a ring-detect pulse, produced by qualification logic outside the block;
- a module interrupt line;
- a software event.

The software event comes from an emulated wake-status register. The control register selects how it is raised. In edge mode, a write that takes wake bit 6 from 0 to 1 raises it. In write mode, any write that carries a 1 in wake bit 1 raises it.

Firmware reaches the block through a plain synchronous register port: write strobe, 2-bit address, write data and a combinational read bus. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Register map (address : register):

| Address | Register | Access |
|---------|----------|--------|
| 0 | status | write-1-to-clear |
| 1 | enable | read/write |
| 2 | control | bit 0 selects the software-event mode |
| 3 | wake | read/write, 8 bits |

The status and enable registers share one bit layout:

| Bit | Source |
|-----|--------|
| 0 | ring indicator 1 |
| 1 | ring indicator 2 |
| 3 | ring detect |
| 6 | software event |
| 7 | module interrupt |

Top module: `host_evt_irq_ctrl`

## Requirements
- R1: After warm reset (rst_n low), the status, enable, control and wake registers all read 0 and irq_o is 0.
- R2: Enable (address 1) implements bits 0, 1, 3, 6 and 7. Reserved bits 2, 4 and 5 read 0 and ignore writes, so writing 0xFF reads back 0xCB.
- R3: At the next clock edge, a high level on ev_ri1_i sets status bit 0, ev_ri2_i sets bit 1, ev_ring_i sets bit 3 and ev_mirq_i sets bit 7. Each bit stays set after its input returns low.
- R4: Writing status (address 0) clears every implemented bit written as 1 and leaves every bit written as 0 unchanged. Reserved status bits always read 0.
- R5: If a set condition and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R6: With control bit 0 = 0, a write to wake (address 3) that changes bit 6 from 0 to 1 sets status bit 6. A write that leaves bit 6 at 1, or that only sets bit 1, does not set it.
- R7: With control bit 0 = 1, every write to wake with data bit 1 = 1 sets status bit 6, even when bit 1 was already 1. A 0-to-1 change of wake bit 6 alone does not set it. Control reads back bit 0 with upper bits 0.
- R8: irq_o is registered. One clock after (status AND enable) is nonzero, irq_o is 1. One clock after that term becomes zero, whether because the status bit or the enable bit was cleared, irq_o is 0.
- R9: Wake (address 3) reads back the last value written, all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| ev_ri1_i | input | 1 | Ring indicator 1 event |
| ev_ri2_i | input | 1 | Ring indicator 2 event |
| ev_ring_i | input | 1 | Qualified ring-detect pulse |
| ev_mirq_i | input | 1 | Module interrupt event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_o | output | 1 | Level-high core interrupt |

## Verification
The assertions check four rules on every cycle:

- a set always lands, including against a simultaneous clear;
- a clear without a set always takes effect;
- a set bit never drops on its own;
- irq_o follows the masked status one cycle later.

Both software-event modes also have assertions that a qualifying wake write raises status bit 6. Only the bench can show the negative cases: the reserved bits staying 0, a write of 0 to status changing nothing, a repeated bit-6 write not counting as an edge, and edge mode ignoring bit 1. It shows these by reading the registers back after targeted writes and comparing them with a reference model during long random runs.

// File: rtl/hevt_pkg.sv
package hevt_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam int BIT_RI1  = 0;
  localparam int BIT_RI2  = 1;
  localparam int BIT_RING = 3;
  localparam int BIT_SW   = 6;
  localparam int BIT_MIRQ = 7;

  // wake register bits used as software-event sources
  localparam int WAKE_EDGE_BIT = 6;
  localparam int WAKE_WR_BIT   = 1;

  localparam logic [DW-1:0] IMPL_MASK = 8'hCB;

  typedef enum logic [AW-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_WAKE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/hevt_status_bank.sv
module hevt_status_bank
  import hevt_pkg::*;
#(
  parameter int              W    = DW,
  parameter logic [W-1:0]    IMPL = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      // set has priority over a same-cycle write-1 clear
      assign st_nxt[i] = set_i[i] | (st_q[i] & ~clr_i[i]);

      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> st_q[i]);
      assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !st_q[i]);
      assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[i] && !clr_i[i]) |=> st_q[i]);
    end else begin : g_rsvd
      assign st_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_nxt;
  end

  assign status_o = st_q;
endmodule

// File: rtl/hevt_swevt_src.sv
module hevt_swevt_src
  import hevt_pkg::*;
#(
  parameter int W  = DW,
  parameter int AWID = AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [AWID-1:0] addr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    wake_o,
  output logic            mode_o,
  output logic            set_o
);
  logic [W-1:0] wake_q;
  logic         mode_q;
  logic         wake_wr;
  logic         ctrl_wr;

  assign wake_wr = wr_i && (addr_i == ADDR_WAKE);
  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wake_wr) wake_q <= wdata_i;
      if (ctrl_wr) mode_q <= wdata_i[0];
    end
  end

  // mode 0: rising edge of the edge bit caused by this write
  // mode 1: any write carrying 1 in the write bit
  always_comb begin
    set_o = 1'b0;
    if (wake_wr) begin
      if (mode_q) set_o = wdata_i[WAKE_WR_BIT];
      else        set_o = wdata_i[WAKE_EDGE_BIT] & ~wake_q[WAKE_EDGE_BIT];
    end
  end

  assign wake_o = wake_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/hevt_irq_gen.sv
module hevt_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & enable_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/host_evt_irq_ctrl.sv
module host_evt_irq_ctrl
  import hevt_pkg::*;
#(
  parameter int W    = DW,
  parameter int AWID = AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_ri1_i,
  input  logic            ev_ri2_i,
  input  logic            ev_ring_i,
  input  logic            ev_mirq_i,
  input  logic            reg_wr_i,
  input  logic [AWID-1:0] reg_addr_i,
  input  logic [W-1:0]    reg_wdata_i,
  output logic [W-1:0]    reg_rdata_o,
  output logic            irq_o
);
  localparam logic [W-1:0] MASK = W'(IMPL_MASK);

  logic [W-1:0] status;
  logic [W-1:0] en_q;
  logic [W-1:0] wake;
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic         mode;
  logic         sw_set;
  logic         masked;

  hevt_swevt_src #(.W(W), .AWID(AWID)) u_swevt (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .wake_o(wake), .mode_o(mode), .set_o(sw_set)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_RI1]  = ev_ri1_i;
    set_vec[BIT_RI2]  = ev_ri2_i;
    set_vec[BIT_RING] = ev_ring_i;
    set_vec[BIT_SW]   = sw_set;
    set_vec[BIT_MIRQ] = ev_mirq_i;
  end

  assign clr_vec = (reg_wr_i && reg_addr_i == ADDR_STATUS) ? (reg_wdata_i & MASK) : '0;

  hevt_status_bank #(.W(W), .IMPL(MASK)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .status_o(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_ENABLE) en_q <= reg_wdata_i & MASK;
  end

  hevt_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_i(status), .enable_i(en_q), .irq_o(irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_STATUS: reg_rdata_o = status;
      ADDR_ENABLE: reg_rdata_o = en_q;
      ADDR_CTRL:   reg_rdata_o = {{(W-1){1'b0}}, mode};
      default:     reg_rdata_o = wake;
    endcase
  end

  assign masked = |(status & en_q);

  assert_irq_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> irq_o);
  assert_irq_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !masked |=> !irq_o);
  assert_edge_mode_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && reg_wr_i && reg_addr_i == ADDR_WAKE && reg_wdata_i[WAKE_EDGE_BIT]
     && !wake[WAKE_EDGE_BIT]) |=> status[BIT_SW]);
  assert_write_mode_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && reg_wr_i && reg_addr_i == ADDR_WAKE && reg_wdata_i[WAKE_WR_BIT])
    |=> status[BIT_SW]);
endmodule

// File: tb/test_host_evt_irq_ctrl.sv
module test_host_evt_irq_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ri1, ri2, ring, mirq, wr, irq;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;

  host_evt_irq_ctrl i_host_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_ri1_i(ri1), .ev_ri2_i(ri2), .ev_ring_i(ring),
    .ev_mirq_i(mirq), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] MASK = 8'hCB;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_st = 8'h00, m_en = 8'h00, m_wake = 8'h00;
  logic m_mode = 1'b0, m_irq = 1'b0;

  function automatic logic [7:0] model_read(input logic [1:0] ad);
    case (ad)
      2'd0: return m_st;
      2'd1: return m_en;
      2'd2: return {7'b0, m_mode};
      default: return m_wake;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic c, input logic d,
                      input logic w, input logic [1:0] ad, input logic [7:0] wd);
    logic [7:0] setv, clrv;
    ri1 = a; ri2 = b; ring = c; mirq = d; wr = w; addr = ad; wdata = wd;
    setv = 8'h00;
    setv[0] = a; setv[1] = b; setv[3] = c; setv[7] = d;
    if (w && ad == 2'd3) setv[6] = m_mode ? wd[1] : (wd[6] & ~m_wake[6]);
    clrv = (w && ad == 2'd0) ? (wd & MASK) : 8'h00;
    m_irq = |(m_st & m_en);
    m_st = ((m_st & ~clrv) | setv) & MASK;
    if (w) begin
      case (ad)
        2'd1: m_en = wd & MASK;
        2'd2: m_mode = wd[0];
        2'd3: m_wake = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] ad, input logic [7:0] wd);
    step(0, 0, 0, 0, 1, ad, wd);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 2'd0, 8'h00);
  endtask

  task automatic peek(input logic [1:0] ad, input string tag);
    ri1 = 0; ri2 = 0; ring = 0; mirq = 0; wr = 0; wdata = 8'h00; addr = ad;
    #1;
    check(tag, rdata, model_read(ad));
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {7'b0, irq}, {7'b0, m_irq});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 0; ri1 = 0; ri2 = 0; ring = 0; mirq = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) peek(2'(a), "R1");
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 reserved enable bits
    wreg(2'd1, 8'hFF);
    peek(2'd1, "R2");
    check("R2 literal", rdata, 8'hCB);
    wreg(2'd1, 8'h00);

    // R3 hardware events, sticky
    step(1, 0, 0, 0, 0, 0, 0);
    idle();
    peek(2'd0, "R3");
    check("R3 ri1 literal", rdata, 8'h01);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    idle();
    peek(2'd0, "R3");
    check("R3 sticky literal", rdata, 8'h8B);

    // R4 write-1-to-clear
    wreg(2'd0, 8'h00);
    peek(2'd0, "R4");
    check("R4 zero write literal", rdata, 8'h8B);
    wreg(2'd0, 8'h0B);
    peek(2'd0, "R4");
    check("R4 clear literal", rdata, 8'h80);

    // R5 set wins over clear
    step(0, 0, 0, 1, 1, 2'd0, 8'h80);
    peek(2'd0, "R5");
    check("R5 literal", rdata, 8'h80);
    wreg(2'd0, 8'h80);
    peek(2'd0, "R4");

    // R6 edge mode
    wreg(2'd3, 8'h40);
    peek(2'd0, "R6");
    check("R6 rise literal", rdata, 8'h40);
    wreg(2'd0, 8'h40);
    wreg(2'd3, 8'h40);
    peek(2'd0, "R6");
    check("R6 no-edge literal", rdata, 8'h00);
    wreg(2'd3, 8'h02);
    peek(2'd0, "R6");
    check("R6 bit1 ignored literal", rdata, 8'h00);
    wreg(2'd3, 8'h00);
    wreg(2'd3, 8'h40);
    peek(2'd0, "R6");
    wreg(2'd0, 8'h40);

    // R9 wake readback
    wreg(2'd3, 8'hA5);
    peek(2'd3, "R9");
    check("R9 literal", rdata, 8'hA5);

    // R7 write mode
    wreg(2'd2, 8'hFF);
    peek(2'd2, "R7");
    check("R7 ctrl literal", rdata, 8'h01);
    wreg(2'd3, 8'h00);
    wreg(2'd3, 8'h40);
    peek(2'd0, "R7");
    check("R7 edge ignored literal", rdata, 8'h00);
    wreg(2'd3, 8'h02);
    peek(2'd0, "R7");
    check("R7 set literal", rdata, 8'h40);
    wreg(2'd0, 8'h40);
    wreg(2'd3, 8'h02);
    peek(2'd0, "R7");
    check("R7 repeat literal", rdata, 8'h40);

    // R8 interrupt level and masking
    wreg(2'd1, 8'h40);
    chk_irq("R8");
    idle();
    chk_irq("R8");
    check("R8 asserted literal", {7'b0, irq}, 8'h01);
    wreg(2'd1, 8'h00);
    chk_irq("R8");
    idle();
    chk_irq("R8");
    check("R8 enable-cleared literal", {7'b0, irq}, 8'h00);
    wreg(2'd1, 8'h40);
    idle();
    chk_irq("R8");
    wreg(2'd0, 8'h40);
    chk_irq("R8");
    idle();
    chk_irq("R8");
    check("R8 status-cleared literal", {7'b0, irq}, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] ra;
      ra = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 2) == 0), ra, 8'($urandom));
      chk_irq("R8");
      ra = 2'($urandom_range(0, 3));
      case (ra)
        2'd0: peek(ra, "R3");
        2'd1: peek(ra, "R2");
        2'd2: peek(ra, "R7");
        default: peek(ra, "R9");
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule